// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is the general-purpose register file of a processor with register windows. Software sees 32 architectural registers at any time. Registers 0 to 7 are global and shared by every window. The other 24 belong to the current window, chosen by a 3-bit window pointer. Those 24 registers form three banks of eight: outs, locals and ins.

Storage holds 8 globals plus 16 unique registers for each of 8 windows, which is 136 physical words. The locals of a window are its own. Its outs are the same physical words as the ins of the window it moves to on a call. A caller therefore puts arguments in its outs and the callee finds them in its ins, with no copying.

The file has three combinational read ports and one write port. A read returns the value written in the same cycle to the same physical word. An advance (call-like) step moves the pointer down by one, and a retreat (return-like) step moves it up by one, both modulo 8. An 8-bit invalid mask marks windows that must be spilled or filled first. A step into a marked window leaves the pointer where it was and raises an overflow or underflow flag, which the trap logic around the block handles.

Top module: `regwin_file`

## Requirements
- R1: After reset the window pointer is 0, the invalid mask is all clear, both flags are low, and every architectural register reads 0 in window 0.
- R2: Architectural register 0 always reads 0. A write addressed to it changes nothing and is not bypassed to any read port.
- R3: Architectural registers 1 to 7 are globals: one storage word each, seen identically from every window.
- R4: Architectural registers 8 to 15 (outs) of window w are the same storage as registers 24 to 31 (ins) of window (w-1) mod 8. The physical word is 8 + ((16*w + a - 8) mod 128) for architectural number a at least 8.
- R5: Architectural registers 16 to 23 (locals) of a window are private to that window.
- R6: Each of the three read ports returns the register named by its own address in the current window, combinationally and independently of the other ports.
- R7: A read of the physical word being written in the same cycle returns the write data (write-first bypass).
- R8: With win_adv alone asserted, the pointer becomes (cwp-1) mod 8 at the clock edge, if that window's mask bit is clear. With win_ret alone asserted, it becomes (cwp+1) mod 8 under the same condition. With both or neither asserted, the pointer holds and no flag is raised.
- R9: An advance whose target window has its mask bit set leaves the pointer unchanged, and win_ovf is high for exactly the one following cycle.
- R10: A retreat whose target window has its mask bit set leaves the pointer unchanged, and win_unf is high for exactly the one following cycle.
- R11: A write in the same cycle as a window step goes to the window that was current before the step.
- R12: mask_we loads mask_in into the invalid mask at the clock edge, with bit i marking window i. A step in the same cycle is judged against the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_addr | input | 3x5 | Architectural register number for each read port |
| rd_data | output | 3x32 | Read data for each port |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number to write |
| wr_data | input | 32 | Write data |
| win_adv | input | 1 | Advance (call-like) window step request |
| win_ret | input | 1 | Retreat (return-like) window step request |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_in | input | 8 | New invalid-window mask, bit i for window i |
| cwp | output | 3 | Current window pointer |
| win_ovf | output | 1 | One-cycle flag: advance refused by the mask |
| win_unf | output | 1 | One-cycle flag: retreat refused by the mask |

## Verification
The tricky case is a write that falls in the same cycle as a window step, and also in the same cycle as reads of the word being written. In directed cases the bench writes an out register while stepping, and writes a local while reading it on another port. It then reads the written value back as an in or a local after the step. Long random runs mix steps, refused steps, mask loads and writes every cycle. A behavioural model built from a shared out/in bank per window boundary, not from the physical index formula, judges every read port, the pointer and both flags on every clock.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Bank selected by the top two bits of an architectural register number
  typedef enum logic [1:0] {
    RC_GLOBAL = 2'd0,
    RC_OUT    = 2'd1,
    RC_LOCAL  = 2'd2,
    RC_IN     = 2'd3
  } reg_class_e;

  // Window step requested in a cycle
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_ADV  = 2'd1,
    MV_RET  = 2'd2
  } win_move_e;

endpackage

// File: rtl/regwin_map.sv
// Maps an architectural register number to a physical storage index.
module regwin_map
  import regwin_pkg::*;
#(
  parameter  int BANK  = 8,
  parameter  int NWIN  = 8,
  localparam int AW    = $clog2(4 * BANK),
  localparam int PW    = $clog2(NWIN),
  localparam int NPHYS = BANK + NWIN * 2 * BANK,
  localparam int IW    = $clog2(NPHYS)
) (
  input  logic [PW-1:0] cwp,
  input  logic [AW-1:0] arch,
  output logic [IW-1:0] phys,
  output logic          is_zero
);

  localparam int unsigned SPAN = 2 * BANK;
  localparam int unsigned RING = NWIN * SPAN;

  reg_class_e  cls;
  int unsigned offset;
  int unsigned slot;

  always_comb begin
    cls     = reg_class_e'(arch[AW-1 -: 2]);
    offset  = 32'(arch) - 32'(BANK);
    slot    = (32'(cwp) * SPAN + offset) % RING;
    is_zero = (arch == '0);
    if (cls == RC_GLOBAL) begin
      phys = IW'(arch);
    end else begin
      phys = IW'(32'(BANK) + slot);
    end
  end

endmodule

// File: rtl/regwin_wptr.sv
// Window pointer, invalid mask and the refused-step flags.
module regwin_wptr
  import regwin_pkg::*;
#(
  parameter  int NWIN = 8,
  localparam int PW   = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            ret,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_in,
  output logic [PW-1:0]   cwp_q,
  output logic [NWIN-1:0] mask_q,
  output logic            ovf_q,
  output logic            unf_q
);

  win_move_e       move;
  logic [PW-1:0]   target;
  logic            blocked;
  logic            cwp_en;
  logic [PW-1:0]   cwp_d;
  logic            mask_en;
  logic [NWIN-1:0] mask_d;
  logic            ovf_d;
  logic            unf_d;

  always_comb begin
    if (adv && !ret) begin
      move = MV_ADV;
    end else if (ret && !adv) begin
      move = MV_RET;
    end else begin
      move = MV_HOLD;
    end
    target  = (move == MV_ADV) ? cwp_q - PW'(1) : cwp_q + PW'(1);
    blocked = mask_q[target];
    cwp_en  = (move != MV_HOLD) && !blocked;
    cwp_d   = target;
    ovf_d   = (move == MV_ADV) && blocked;
    unf_d   = (move == MV_RET) && blocked;
    mask_en = mask_we;
    mask_d  = mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      mask_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (cwp_en) begin
        cwp_q <= cwp_d;
      end
      if (mask_en) begin
        mask_q <= mask_d;
      end
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

endmodule

// File: rtl/regwin_store.sv
// Flat physical storage: one write port, NRD raw read ports.
module regwin_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int NRD   = 3,
  parameter int IW    = $clog2(NPHYS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IW-1:0]           widx,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][IW-1:0]  ridx,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  logic [DW-1:0]    mem_q [NPHYS];
  logic [NPHYS-1:0] ent_en;

  always_comb begin
    for (int e = 0; e < NPHYS; e++) begin
      ent_en[e] = we && (widx == IW'(e));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NPHYS; e++) begin
        mem_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NPHYS; e++) begin
        if (ent_en[e]) begin
          mem_q[e] <= wdata;
        end
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[ridx[p]];
  end

endmodule

// File: rtl/regwin_file.sv
// Overlapping windowed register file: top level.
module regwin_file #(
  parameter  int DW    = 32,
  parameter  int BANK  = 8,
  parameter  int NWIN  = 8,
  parameter  int NRD   = 3,
  localparam int AW    = $clog2(4 * BANK),
  localparam int PW    = $clog2(NWIN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][DW-1:0] rd_data,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   win_adv,
  input  logic                   win_ret,
  input  logic                   mask_we,
  input  logic [NWIN-1:0]        mask_in,
  output logic [PW-1:0]          cwp,
  output logic                   win_ovf,
  output logic                   win_unf
);

  localparam int NPHYS = BANK + NWIN * 2 * BANK;
  localparam int IW    = $clog2(NPHYS);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [NWIN-1:0] mask_q;

  regwin_wptr #(.NWIN(NWIN)) u_wptr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .adv     (win_adv),
    .ret     (win_ret),
    .mask_we (mask_we),
    .mask_in (mask_in),
    .cwp_q   (cwp),
    .mask_q  (mask_q),
    .ovf_q   (win_ovf),
    .unf_q   (win_unf)
  );

  // Write path: mapped with the pointer current in this cycle
  logic [IW-1:0] wr_phys;
  logic          wr_is_zero;
  logic          wr_live;

  regwin_map #(.BANK(BANK), .NWIN(NWIN)) u_wmap (
    .cwp     (cwp),
    .arch    (wr_addr),
    .phys    (wr_phys),
    .is_zero (wr_is_zero)
  );
  assign wr_live = wr_en && !wr_is_zero;

  logic [NRD-1:0][IW-1:0] rd_phys;
  logic [NRD-1:0]         rd_is_zero;
  logic [NRD-1:0][DW-1:0] rd_raw;

  regwin_store #(.DW(DW), .NPHYS(NPHYS), .NRD(NRD), .IW(IW)) u_store (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (wr_live),
    .widx  (wr_phys),
    .wdata (wr_data),
    .ridx  (rd_phys),
    .rdata (rd_raw)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    logic hit;

    regwin_map #(.BANK(BANK), .NWIN(NWIN)) u_rmap (
      .cwp     (cwp),
      .arch    (rd_addr[p]),
      .phys    (rd_phys[p]),
      .is_zero (rd_is_zero[p])
    );

    assign hit = wr_live && (wr_phys == rd_phys[p]);

    always_comb begin
      if (rd_is_zero[p]) begin
        rd_data[p] = '0;
      end else if (hit) begin
        rd_data[p] = wr_data;
      end else begin
        rd_data[p] = rd_raw[p];
      end
    end
  end

endmodule

// File: rtl/regwin_chk.sv
// Property checker attached to regwin_file.
module regwin_chk #(
  parameter  int DW   = 32,
  parameter  int BANK = 8,
  parameter  int NWIN = 8,
  parameter  int NRD  = 3,
  localparam int AW   = $clog2(4 * BANK),
  localparam int PW   = $clog2(NWIN)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NRD-1:0][AW-1:0] rd_addr,
  input logic [NRD-1:0][DW-1:0] rd_data,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic                   win_adv,
  input logic                   win_ret,
  input logic [PW-1:0]          cwp,
  input logic                   win_ovf,
  input logic                   win_unf
);

  for (genvar p = 0; p < NRD; p++) begin : g_port
    // R2
    r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[p] == '0) |-> (rd_data[p] == '0));
  end

  // R7
  bypass_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != '0) && (rd_addr[0] == wr_addr)) |-> (rd_data[0] == wr_data));

  // R8
  cwp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwp != $past(cwp)) |->
      (($past(win_adv) && !$past(win_ret) && (cwp == PW'($past(cwp) - PW'(1)))) ||
       ($past(win_ret) && !$past(win_adv) && (cwp == PW'($past(cwp) + PW'(1))))));

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_ovf |-> $stable(cwp));

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_ovf |-> ($past(win_adv) && !$past(win_ret)));

  // R10
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_unf |-> $stable(cwp));

  // R10
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_unf |-> ($past(win_ret) && !$past(win_adv)));

endmodule

bind regwin_file regwin_chk #(
  .DW(DW), .BANK(BANK), .NWIN(NWIN), .NRD(NRD)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .win_adv (win_adv),
  .win_ret (win_ret),
  .cwp     (cwp),
  .win_ovf (win_ovf),
  .win_unf (win_unf)
);

// File: tb/regwin_file_tb.sv
`timescale 1ns/1ps
module regwin_file_tb;

  localparam int DW  = 32;
  localparam int NRD = 3;
  localparam int AW  = 5;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;
  logic                   wr_en;
  logic [AW-1:0]          wr_addr;
  logic [DW-1:0]          wr_data;
  logic                   win_adv;
  logic                   win_ret;
  logic                   mask_we;
  logic [7:0]             mask_in;
  logic [2:0]             cwp;
  logic                   win_ovf;
  logic                   win_unf;

  always #4 clk = ~clk;   // 125 MHz

  regwin_file u_dut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_adv(win_adv), .win_ret(win_ret), .mask_we(mask_we), .mask_in(mask_in),
    .cwp(cwp), .win_ovf(win_ovf), .win_unf(win_unf)
  );

  int n_chk  = 0;
  int n_fail = 0;
  string force_tag = "";

  // Behavioural model: globals, one shared bank per window boundary, private locals
  logic [DW-1:0] m_glob [8];
  logic [DW-1:0] m_shr  [8][8];
  logic [DW-1:0] m_loc  [8][8];
  int            m_cwp;
  logic [7:0]    m_mask;
  logic          m_ovf, m_unf;

  function automatic int loc_key(int w, int a);
    if (a < 8)       return a;
    else if (a < 16) return 100 + w * 8 + (a - 8);
    else if (a < 24) return 200 + w * 8 + (a - 16);
    else             return 100 + ((w + 1) % 8) * 8 + (a - 24);
  endfunction

  function automatic logic [DW-1:0] m_read(int w, int a);
    if (a == 0)      return '0;
    else if (a < 8)  return m_glob[a];
    else if (a < 16) return m_shr[w][a-8];
    else if (a < 24) return m_loc[w][a-16];
    else             return m_shr[(w+1)%8][a-24];
  endfunction

  task automatic m_write(int w, int a, logic [DW-1:0] d);
    if (a == 0)      ;
    else if (a < 8)  m_glob[a] = d;
    else if (a < 16) m_shr[w][a-8] = d;
    else if (a < 24) m_loc[w][a-16] = d;
    else             m_shr[(w+1)%8][a-24] = d;
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string cat_tag(int a);
    if (a == 0)                  return "R2";
    else if (a < 8)              return "R3";
    else if (a >= 16 && a < 24)  return "R5";
    else                         return "R4";
  endfunction

  task automatic idle();
    rd_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    win_adv = 1'b0; win_ret = 1'b0; mask_we = 1'b0; mask_in = '0;
  endtask

  // Called just after a falling edge with inputs driven; returns at the next falling edge
  task automatic tick();
    logic [DW-1:0] exp;
    int a, t;
    bit bypass;
    #1;
    for (int p = 0; p < NRD; p++) begin
      a = int'(rd_addr[p]);
      bypass = wr_en && (a != 0) && (wr_addr != '0) &&
               (loc_key(m_cwp, a) == loc_key(m_cwp, int'(wr_addr)));
      exp = bypass ? wr_data : m_read(m_cwp, a);
      if (force_tag != "")
        chk($sformatf("%s port%0d addr%0d", force_tag, p, a), rd_data[p], exp);
      else if (bypass)
        chk($sformatf("R7 port%0d addr%0d", p, a), rd_data[p], exp);
      else
        chk($sformatf("R6 port%0d %s addr%0d", p, cat_tag(a), a), rd_data[p], exp);
    end
    @(posedge clk);
    if (wr_en) m_write(m_cwp, int'(wr_addr), wr_data);   // R11: old window
    m_ovf = 1'b0; m_unf = 1'b0;
    if (win_adv && !win_ret) begin
      t = (m_cwp + 7) % 8;
      if (m_mask[t]) m_ovf = 1'b1; else m_cwp = t;
    end else if (win_ret && !win_adv) begin
      t = (m_cwp + 1) % 8;
      if (m_mask[t]) m_unf = 1'b1; else m_cwp = t;
    end
    if (mask_we) m_mask = mask_in;                        // R12
    @(negedge clk);
    chk((force_tag != "") ? force_tag : "R8 cwp", 32'(cwp), 32'(m_cwp));
    chk((force_tag != "") ? force_tag : "R9 ovf", 32'(win_ovf), 32'(m_ovf));
    chk((force_tag != "") ? force_tag : "R10 unf", 32'(win_unf), 32'(m_unf));
    idle();
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_glob[i] = '0;
      for (int j = 0; j < 8; j++) begin m_shr[i][j] = '0; m_loc[i][j] = '0; end
    end
    m_cwp = 0; m_mask = '0; m_ovf = 1'b0; m_unf = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, every register in window 0 reads zero
    force_tag = "R1";
    for (int k = 0; k < 11; k++) begin
      for (int p = 0; p < NRD; p++) rd_addr[p] = AW'((k * 3 + p) % 32);
      tick();
    end
    force_tag = "";

    // R2: write to register 0 is dropped and not bypassed
    wr(0, 32'hDEAD_BEEF); rd_addr[0] = 5'd0; tick();
    rd_addr[1] = 5'd0; tick();

    // R3: globals written in window 0, read after moving windows
    for (int g = 1; g < 8; g++) begin wr(g, 32'h1000_0000 + g); tick(); end
    win_adv = 1'b1; tick();
    win_adv = 1'b1; tick();
    rd_addr[0] = 5'd1; rd_addr[1] = 5'd4; rd_addr[2] = 5'd7; tick();

    // R4: outs of the current window become ins after an advance
    for (int o = 8; o < 16; o++) begin wr(o, 32'hA000_0000 + o); tick(); end
    win_adv = 1'b1; tick();
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p < NRD; p++) rd_addr[p] = AW'(24 + k * 3 + p - ((k == 2 && p == 2) ? 3 : 0));
      tick();
    end
    win_ret = 1'b1; tick();
    rd_addr[0] = 5'd8; rd_addr[1] = 5'd15; tick();

    // R5: locals are private to each window
    wr(17, 32'h5151_0017); tick();
    win_adv = 1'b1; tick();
    rd_addr[0] = 5'd17; tick();
    wr(17, 32'h7777_0017); tick();
    win_ret = 1'b1; tick();
    rd_addr[2] = 5'd17; tick();

    // R7 with R6: bypass on one port, other ports read unrelated registers
    wr(18, 32'hB0B0_0018); rd_addr[0] = 5'd3; rd_addr[1] = 5'd18; rd_addr[2] = 5'd9; tick();

    // R11: write an out in the same cycle as an advance, read it back as an in
    wr(9, 32'hC0DE_0009); win_adv = 1'b1; tick();
    rd_addr[0] = 5'd25; rd_addr[1] = 5'd9; tick();

    // R12 / R9 / R10: mask refuses steps
    mask_we = 1'b1; mask_in = 8'h00; mask_in[(m_cwp + 7) % 8] = 1'b1;
    mask_in[(m_cwp + 1) % 8] = 1'b1; tick();
    win_adv = 1'b1; tick();
    tick();
    win_ret = 1'b1; tick();
    // R12: step and mask load in one cycle use the old mask
    win_adv = 1'b1; mask_we = 1'b1; mask_in = 8'h00; tick();
    win_adv = 1'b1; tick();
    // R8: both requests together do nothing
    win_adv = 1'b1; win_ret = 1'b1; tick();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      for (int p = 0; p < NRD; p++) rd_addr[p] = AW'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) wr(int'($urandom_range(0, 31)), DW'($urandom()));
      if ($urandom_range(0, 3) == 0) rd_addr[$urandom_range(0, 2)] = wr_addr;
      r = int'($urandom_range(0, 19));
      if (r < 3) win_adv = 1'b1;
      else if (r < 6) win_ret = 1'b1;
      else if (r == 6) begin win_adv = 1'b1; win_ret = 1'b1; end
      if ($urandom_range(0, 49) == 0) begin
        mask_we = 1'b1;
        mask_in = 8'(1 << $urandom_range(0, 7)) | 8'(1 << $urandom_range(0, 7));
      end
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule